// File: doc/BRIEF.md
# Physical Memory Region Guard

This block decides whether a memory access may go ahead. It compares the physical address of the access against a set of protection regions that machine mode programs. Each region has an address register and a configuration byte. The configuration byte holds the matching mode, the read, write and execute permissions, and a lock bit. Supervisor-mode and user-mode accesses are allowed only where a region grants the requested kind of access. Machine-mode accesses are allowed unless a locked region matches. The decision is purely combinational from the request inputs and the stored registers. The registers themselves sit behind a simple CSR-style write port and a combinational read port.

Region matching supports naturally aligned power-of-two regions, four-byte (granule) regions and top-of-range regions. Top-of-range regions use the address of the region below as their lower bound. A parameter can compile out top-of-range matching. A granularity parameter, 4096 bytes by default and 4 bytes at minimum, discards the low address bits from every comparison. This trades fine resolution for narrower comparators.

Top module: `pmp_guard`

## Requirements
- R1: After reset every configuration byte and address register reads as zero. Supervisor and user accesses are then denied, and machine accesses are allowed.
- R2: With `csr_sel`=0, a write stores `csr_wdata[7:0]` into the configuration byte of region `csr_idx`. The byte layout is: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. Bits 6:5 always read as zero. With `csr_sel`=1, a write stores the word address (byte address shifted right by 2) into the address register. Reads return the selected register zero-extended.
- R3: In power-of-two mode, a region whose address register ends in t one bits covers 2^(t+3) bytes, aligned to that size.
- R4: In top-of-range mode, region i matches addresses from the address of region i-1 inclusive (zero for region 0) up to its own address exclusive. When `TOR_EN`=0, a region in this mode never matches, though its byte is still stored.
- R5: In four-byte mode, a region matches the single granule that contains its address.
- R6: Address bits below the granularity `GRAN` are ignored in every bound and comparison.
- R7: When several regions match, the lowest-numbered one alone decides the access.
- R8: When no region matches, supervisor and user accesses are denied and machine accesses are allowed.
- R9: A machine access (`req_priv`=3) that matches an unlocked region is allowed. If it matches a locked region, that region's permissions apply.
- R10: While a region's lock bit is set, writes to its configuration byte and to its address register are ignored.
- R11: `req_kind` 0 is read, 1 is write and 2 is execute, and each is checked against the matching permission bit. Kind 3 is always denied. `req_priv` 0 is user and 1 is supervisor.
- R12: `req_allow` follows the request inputs within the same cycle. A register write affects the decision from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects configuration byte, 1 selects address register |
| csr_idx | input | IW | Region index for read and write |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register |
| req_addr | input | AW | Physical byte address of the access |
| req_priv | input | 2 | Privilege of the access: 0 user, 1 supervisor, 3 machine |
| req_kind | input | 2 | Kind of access: 0 read, 1 write, 2 execute |
| req_allow | output | 1 | 1 when the access is permitted |

## Verification
The allow decision has no register in its path, so it is due in the same cycle as the request. A register write lands on the rising edge where `csr_we` is high. The bench drives every input on the falling edge and samples one nanosecond later. Each decision check therefore sees the settled result of the current request, plus every write stored at an earlier rising edge. Reads of the configuration and address registers are timed the same way. A locked-write check reads the register back on the cycle after the ignored write, and confirms that neither the value nor the decision moved.

// File: rtl/pmp_guard.sv
module pmp_guard #(
  parameter int NREG   = 4,
  parameter int AW     = 32,
  parameter int GRAN   = 4096,
  parameter bit TOR_EN = 1'b1,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic          csr_sel,
  input  logic [IW-1:0] csr_idx,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_priv,
  input  logic [1:0]    req_kind,
  output logic          req_allow
);
  localparam int GB = $clog2(GRAN);
  localparam logic [AW-1:0] GMASK = {AW{1'b1}} << GB;
  localparam logic [1:0] MODE_OFF = 2'd0, MODE_TOR = 2'd1, MODE_NA4 = 2'd2, MODE_POW2 = 2'd3;
  localparam logic [1:0] PRIV_M = 2'd3;

  logic [7:0]    cfg_q [NREG];
  logic [AW-3:0] adr_q [NREG];
  logic [NREG-1:0] hit, win, lk;
  logic [AW-1:0] rq;
  logic [7:0]    pick;

  assign rq = req_addr & GMASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        cfg_q[i] <= '0;
        adr_q[i] <= '0;
      end
    end else if (csr_we && !cfg_q[csr_idx][7]) begin
      if (csr_sel) adr_q[csr_idx] <= csr_wdata[AW-3:0];
      else         cfg_q[csr_idx] <= {csr_wdata[7], 2'b00, csr_wdata[4:0]};
    end
  end

  assign csr_rdata = csr_sel ? 32'(adr_q[csr_idx]) : {24'b0, cfg_q[csr_idx]};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [AW-1:0] base, lo, care;
    logic [AW-3:0] ones;
    logic          tor_hit;
    assign base = {adr_q[i], 2'b00};
    assign ones = adr_q[i] ^ (adr_q[i] + 1'b1);
    assign care = ~{ones, 2'b11} & GMASK;
    if (i == 0) begin : g_lo0
      assign lo = '0;
    end else begin : g_lon
      assign lo = {adr_q[i-1], 2'b00};
    end
    assign tor_hit = TOR_EN && (rq >= (lo & GMASK)) && (rq < (base & GMASK));
    assign lk[i] = cfg_q[i][7];
    always_comb begin
      case (cfg_q[i][4:3])
        MODE_TOR:  hit[i] = tor_hit;
        MODE_NA4:  hit[i] = ((req_addr ^ base) & GMASK & ~AW'(3)) == '0;
        MODE_POW2: hit[i] = ((req_addr ^ base) & care) == '0;
        default:   hit[i] = 1'b0;
      endcase
    end

    assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_idx == IW'(i) && cfg_q[i][7]) |=> ($stable(cfg_q[i]) && $stable(adr_q[i])))
      else $error("assert_locked_frozen_R10 region %0d", i);
    assert property (@(posedge clk) disable iff (!rst_n)
      (!TOR_EN && cfg_q[i][4:3] == MODE_TOR) |-> !hit[i])
      else $error("assert_tor_removed_R4 region %0d", i);
  end

  assign win = hit & (~hit + 1'b1);

  always_comb begin
    pick = '0;
    for (int i = 0; i < NREG; i++)
      if (win[i]) pick = cfg_q[i];
  end

  always_comb begin
    if (hit == '0)                        req_allow = (req_priv == PRIV_M);
    else if (req_priv == PRIV_M && !pick[7]) req_allow = 1'b1;
    else if (req_kind == 2'd3)            req_allow = 1'b0;
    else                                  req_allow = pick[req_kind];
  end

  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win))
    else $error("assert_single_winner_R7");
  assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && req_priv != PRIV_M) |-> !req_allow)
    else $error("assert_unmatched_deny_R8");
  assert property (@(posedge clk) disable iff (!rst_n)
    (req_priv == PRIV_M && (win & lk) == '0) |-> req_allow)
    else $error("assert_machine_pass_R9");
  assert property (@(posedge clk) disable iff (!rst_n)
    !csr_sel |-> (csr_rdata[31:8] == '0 && csr_rdata[6:5] == 2'b00))
    else $error("assert_cfg_reserved_zero_R2");
endmodule

// File: tb/pmp_guard_bench.sv
module pmp_guard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, we_n = 1'b0, sel = 1'b0;
  logic [1:0] idx = '0, priv = '0, kind = '0;
  logic [31:0] wdata = '0, addr = '0;
  logic [31:0] rdata, rdata_n;
  logic allow, allow_n;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pmp_guard u_pmp_guard (.clk(clk), .rst_n(rst_n), .csr_we(we), .csr_sel(sel), .csr_idx(idx),
    .csr_wdata(wdata), .csr_rdata(rdata), .req_addr(addr), .req_priv(priv), .req_kind(kind),
    .req_allow(allow));
  pmp_guard #(.TOR_EN(1'b0)) u_pmp_guard_notor (.clk(clk), .rst_n(rst_n), .csr_we(we_n),
    .csr_sel(sel), .csr_idx(idx), .csr_wdata(wdata), .csr_rdata(rdata_n), .req_addr(addr),
    .req_priv(priv), .req_kind(kind), .req_allow(allow_n));

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [1:0] i, input logic [31:0] d, input bit notor = 0);
    @(negedge clk);
    sel = s; idx = i; wdata = d;
    if (notor) we_n = 1'b1; else we = 1'b1;
    @(negedge clk);
    we = 1'b0; we_n = 1'b0;
  endtask

  task automatic rd(input string tag, input logic s, input logic [1:0] i, input logic [31:0] exp);
    @(negedge clk);
    sel = s; idx = i;
    #1 cmp(tag, rdata, exp);
  endtask

  task automatic acc(input string tag, input logic [31:0] a, input logic [1:0] p,
                     input logic [1:0] k, input logic exp);
    @(negedge clk);
    addr = a; priv = p; kind = k;
    #1 cmp(tag, 32'(allow), 32'(exp));
  endtask

  task automatic t_reset;
    rd("R1 cfg0 reset", 1'b0, 2'd0, 32'h0);
    rd("R1 addr3 reset", 1'b1, 2'd3, 32'h0);
    acc("R1 user denied", 32'h0000_1000, 2'd0, 2'd0, 1'b0);
    acc("R1 machine allowed", 32'h0000_1000, 2'd3, 2'd1, 1'b1);
  endtask

  task automatic t_pow2;
    wr(1'b1, 2'd0, 32'h0400_1FFF);
    wr(1'b0, 2'd0, 32'h19);
    rd("R2 cfg0 readback", 1'b0, 2'd0, 32'h19);
    rd("R2 addr0 readback", 1'b1, 2'd0, 32'h0400_1FFF);
    acc("R3 top of 64K read", 32'h1000_FFFC, 2'd0, 2'd0, 1'b1);
    acc("R11 write denied", 32'h1000_FFFC, 2'd0, 2'd1, 1'b0);
    acc("R3 base read", 32'h1000_0000, 2'd1, 2'd0, 1'b1);
    acc("R3 past end", 32'h1001_0000, 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_tor;
    wr(1'b1, 2'd1, 32'h0800_0100);
    wr(1'b0, 2'd1, 32'h0F);
    acc("R4 inside write", 32'h1800_0000, 2'd1, 2'd1, 1'b1);
    acc("R6 upper rounded", 32'h1FFF_FFFC, 2'd0, 2'd2, 1'b1);
    acc("R6 upper exclusive", 32'h2000_0200, 2'd0, 2'd0, 1'b0);
    acc("R7 lower region wins", 32'h1000_8000, 2'd0, 2'd1, 1'b0);
    acc("R4 beyond first", 32'h1001_0000, 2'd0, 2'd1, 1'b1);
    acc("R6 lower rounded", 32'h1000_7000, 2'd0, 2'd1, 1'b0);
    acc("R11 kind3 denied", 32'h1800_0000, 2'd0, 2'd3, 1'b0);
  endtask

  task automatic t_lock;
    wr(1'b1, 2'd2, 32'h0C00_01FF);
    wr(1'b0, 2'd2, 32'h9C);
    acc("R9 locked machine read", 32'h3000_0000, 2'd3, 2'd0, 1'b0);
    acc("R9 locked machine exec", 32'h3000_0FFC, 2'd3, 2'd2, 1'b1);
    acc("R11 user exec", 32'h3000_0000, 2'd0, 2'd2, 1'b1);
    wr(1'b0, 2'd2, 32'h1F);
    rd("R10 cfg unchanged", 1'b0, 2'd2, 32'h9C);
    wr(1'b1, 2'd2, 32'h0D00_0000);
    rd("R10 addr unchanged", 1'b1, 2'd2, 32'h0C00_01FF);
    acc("R10 read still denied", 32'h3000_0000, 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_machine;
    acc("R8 machine unmatched", 32'h5000_0000, 2'd3, 2'd1, 1'b1);
    acc("R8 user unmatched", 32'h5000_0000, 2'd0, 2'd0, 1'b0);
    acc("R9 machine unlocked", 32'h1000_0000, 2'd3, 2'd1, 1'b1);
  endtask

  task automatic t_na4;
    wr(1'b1, 2'd3, 32'h1000_0000);
    wr(1'b0, 2'd3, 32'h60);
    rd("R2 reserved bits zero", 1'b0, 2'd3, 32'h0);
    acc("R2 mode off no match", 32'h4000_0000, 2'd0, 2'd0, 1'b0);
    wr(1'b0, 2'd3, 32'h11);
    acc("R12 same cycle after write", 32'h4000_0000, 2'd0, 2'd0, 1'b1);
    acc("R5 granule end", 32'h4000_0FFC, 2'd0, 2'd0, 1'b1);
    acc("R5 next granule", 32'h4000_1000, 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_notor;
    wr(1'b1, 2'd0, 32'h0800_0000, 1);
    wr(1'b0, 2'd0, 32'h0F, 1);
    @(negedge clk);
    sel = 1'b0; idx = 2'd0; addr = 32'h0000_1000; priv = 2'd0; kind = 2'd0;
    #1;
    cmp("R4 disabled cfg stored", rdata_n, 32'h0F);
    cmp("R4 disabled no match", 32'(allow_n), 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_pow2;
    t_tor;
    t_lock;
    t_machine;
    t_na4;
    t_notor;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule